// File: doc/BRIEF.md
# Geometry-Probe Aliasing Memory

This block stands in front of a memory port and imitates what a smaller physical DRAM does when boot firmware probes it with a larger assumed geometry. The real chip geometry is fixed by the `MEM_SIZE_MB` parameter. The geometry that firmware has programmed arrives on three plain width inputs. While the two geometries differ, requests that fall in the lowest 1 GiB of the memory space are served from a small aliased cell array. Outside that window, and whenever the geometries agree, requests go through unchanged to a backing-memory port.

To find a cell, the block splits the request offset into a column field, a bank field and a row field, using the programmed widths. Each field is then reduced to the position of its most significant set bit. Sparse probe addresses, each with a single bit set, therefore land on distinct cells, and addresses that share the same top bits land on the same cell.

Requests and responses use valid/ready handshakes. The block holds at most one request at a time: `req_ready` is high only when it is idle. Every accepted request, read or write, returns exactly one response beat. A response stays valid with stable data until `rsp_ready` is seen high. The backing port follows the same rules in both directions.

Top module: `probe_alias_mem`

## Requirements
- R1: The real geometry is 3 bank bits and 13 column bits, with 12 row bits for 256 MiB, 13 for 512 MiB and 14 for 1024 MiB. Any other size is unsupported and drives `size_err` high; a supported size drives it low.
- R2: `intercept_on` is high exactly when the size is supported and at least one of `cfg_row_bits`, `cfg_bank_bits` or `cfg_col_bits` differs from the real geometry.
- R3: The column field is the lowest `cfg_col_bits` bits of the offset. The bank field is the next `cfg_bank_bits` bits. The row field is the next `cfg_row_bits` bits above those.
- R4: Each field maps to the position of its highest set bit. Only positions below the real width of that field count (row 12/13/14, bank 3, column 13). A field with no counted bit set maps to 0.
- R5: An intercepted write stores its data in the selected cell. An intercepted read returns that cell. Offsets that map to the same three positions alias to the same cell.
- R6: Interception applies only to offsets below 2^30 (bits 31:30 zero). Higher offsets are always forwarded.
- R7: A request that is not intercepted goes to the backing port with the same write flag, address and data. The backing port's response data is returned as the response.
- R8: With an unsupported size, reads return 0 and writes are dropped. Nothing is forwarded to the backing port.
- R9: After reset, every cell reads as 0.
- R10: While a request is being served, `req_ready` is low. A pending response holds `rsp_valid` and `rsp_rdata` until `rsp_ready` is high. An intercepted write answers with data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_row_bits | input | 5 | Programmed row width |
| cfg_bank_bits | input | 5 | Programmed bank width |
| cfg_col_bits | input | 5 | Programmed column width |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Offset from memory base |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed when high with rsp_valid |
| rsp_rdata | output | DATA_W | Read data (0 for intercepted writes) |
| mem_req_valid | output | 1 | Forwarded request valid |
| mem_req_ready | input | 1 | Backing port accepts request |
| mem_req_write | output | 1 | Forwarded write flag |
| mem_req_addr | output | ADDR_W | Forwarded address |
| mem_req_wdata | output | DATA_W | Forwarded write data |
| mem_rsp_valid | input | 1 | Backing response valid |
| mem_rsp_ready | output | 1 | Backing response consumed |
| mem_rsp_rdata | input | DATA_W | Backing response data |
| intercept_on | output | 1 | Geometry mismatch, window active |
| size_err | output | 1 | Size parameter unsupported |

## Verification
A wrong field split or a wrong highest-bit reduction sends a write to the wrong cell. This does not show on the write itself. It shows on the next read of an aliasing address, which returns a stale value, or on a read of a sparse address, which returns the written value where 0 is expected. Changing the programmed widths between a write and a read exposes a wrong split point at once. A wrong mismatch or window decision shows one cycle after acceptance: the backing port sees a request it should not, or misses one it should get. A handshake fault shows as response data that changes while `rsp_ready` is held low.

// File: rtl/pam_pkg.sv
package pam_pkg;
  localparam int ACT_BANK_BITS = 3;
  localparam int ACT_COL_BITS  = 13;
  localparam int CELL_ROWS     = 16;
  localparam int CELL_BANKS    = 3;
  localparam int CELL_COLS     = 13;

  typedef enum logic [1:0] {ST_IDLE, ST_LOCAL, ST_FWD_REQ, ST_FWD_RSP} pam_state_e;

  typedef struct packed {
    logic [3:0] row;
    logic [1:0] bank;
    logic [3:0] col;
  } cell_sel_t;

  // Real row width for a supported size in MiB, 0 if unsupported.
  function automatic int real_row_bits(input int size_mb);
    case (size_mb)
      256:     return 12;
      512:     return 13;
      1024:    return 14;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/msb_pos.sv
module msb_pos #(
  parameter int W  = 13,
  parameter int IW = 4
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] pos
);
  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) pos = IW'(i);
    end
  end
endmodule

// File: rtl/probe_decoder.sv
module probe_decoder
  import pam_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ROW_W  = 12,
  parameter int BANK_W = 3,
  parameter int COL_W  = 13
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [4:0]        cfg_row_bits,
  input  logic [4:0]        cfg_bank_bits,
  input  logic [4:0]        cfg_col_bits,
  output cell_sel_t         sel
);
  function automatic logic [ADDR_W-1:0] low_mask(input logic [4:0] n);
    if (int'(n) >= ADDR_W) return '1;
    return (ADDR_W'(1) << n) - ADDR_W'(1);
  endfunction

  logic [5:0]        row_shift;
  logic [ADDR_W-1:0] col_f, bank_f, row_f;

  always_comb begin
    row_shift = {1'b0, cfg_col_bits} + {1'b0, cfg_bank_bits};
    col_f     = addr & low_mask(cfg_col_bits);
    bank_f    = (addr >> cfg_col_bits) & low_mask(cfg_bank_bits);
    row_f     = (addr >> row_shift) & low_mask(cfg_row_bits);
  end

  msb_pos #(.W(COL_W),  .IW(4)) u_col  (.vec(col_f[COL_W-1:0]),   .pos(sel.col));
  msb_pos #(.W(BANK_W), .IW(2)) u_bank (.vec(bank_f[BANK_W-1:0]), .pos(sel.bank));
  msb_pos #(.W(ROW_W),  .IW(4)) u_row  (.vec(row_f[ROW_W-1:0]),   .pos(sel.row));
endmodule

// File: rtl/cell_store.sv
module cell_store
  import pam_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ROWS   = CELL_ROWS,
  parameter int BANKS  = CELL_BANKS,
  parameter int COLS   = CELL_COLS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  cell_sel_t         sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = ROWS * BANKS * COLS;
  localparam int AW    = $clog2(DEPTH);

  logic [DATA_W-1:0] cells [DEPTH];
  logic [AW-1:0]     idx;

  always_comb begin
    idx = AW'(sel.row) * AW'(BANKS * COLS) + AW'(sel.bank) * AW'(COLS) + AW'(sel.col);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      rdata <= '0;
    end else if (en) begin
      if (we) begin
        cells[idx] <= wdata;
        rdata      <= '0;
      end else begin
        rdata <= cells[idx];
      end
    end
  end

  // R5
  cell_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (int'(idx) < DEPTH));
endmodule

// File: rtl/probe_alias_mem.sv
module probe_alias_mem
  import pam_pkg::*;
#(
  parameter int MEM_SIZE_MB = 256,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int WIN_BITS    = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        cfg_row_bits,
  input  logic [4:0]        cfg_bank_bits,
  input  logic [4:0]        cfg_col_bits,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic              intercept_on,
  output logic              size_err
);
  localparam int  ROW_RAW = real_row_bits(MEM_SIZE_MB);
  localparam bit  SIZE_OK = (ROW_RAW != 0);
  localparam int  ACT_ROW = SIZE_OK ? ROW_RAW : 12;

  pam_state_e        state;
  logic              accept, in_win, go_local, store_en, loc_zero;
  cell_sel_t         dec_sel;
  logic [DATA_W-1:0] store_rdata;
  logic              fwd_write;
  logic [ADDR_W-1:0] fwd_addr;
  logic [DATA_W-1:0] fwd_wdata;

  always_comb begin
    size_err     = !SIZE_OK;
    intercept_on = SIZE_OK && ((int'(cfg_row_bits)  != ACT_ROW)       ||
                               (int'(cfg_bank_bits) != ACT_BANK_BITS) ||
                               (int'(cfg_col_bits)  != ACT_COL_BITS));
    in_win       = ((req_addr >> WIN_BITS) == '0);
    req_ready    = (state == ST_IDLE);
    accept       = req_valid && req_ready;
    go_local     = !SIZE_OK || (intercept_on && in_win);
    store_en     = accept && go_local && SIZE_OK;
  end

  probe_decoder #(
    .ADDR_W(ADDR_W), .ROW_W(ACT_ROW), .BANK_W(ACT_BANK_BITS), .COL_W(ACT_COL_BITS)
  ) u_dec (
    .addr(req_addr), .cfg_row_bits(cfg_row_bits), .cfg_bank_bits(cfg_bank_bits),
    .cfg_col_bits(cfg_col_bits), .sel(dec_sel)
  );

  cell_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .en(store_en), .we(req_write),
    .sel(dec_sel), .wdata(req_wdata), .rdata(store_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      loc_zero  <= 1'b0;
      fwd_write <= 1'b0;
      fwd_addr  <= '0;
      fwd_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          loc_zero  <= !SIZE_OK;
          fwd_write <= req_write;
          fwd_addr  <= req_addr;
          fwd_wdata <= req_wdata;
          state     <= go_local ? ST_LOCAL : ST_FWD_REQ;
        end
        ST_LOCAL:   if (rsp_ready) state <= ST_IDLE;
        ST_FWD_REQ: if (mem_req_ready) state <= ST_FWD_RSP;
        ST_FWD_RSP: if (mem_rsp_valid && rsp_ready) state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_valid = (state == ST_FWD_REQ);
    mem_req_write = fwd_write;
    mem_req_addr  = fwd_addr;
    mem_req_wdata = fwd_wdata;
    mem_rsp_ready = (state == ST_FWD_RSP) && rsp_ready;
    rsp_valid     = (state == ST_LOCAL) || ((state == ST_FWD_RSP) && mem_rsp_valid);
    if (state == ST_FWD_RSP) rsp_rdata = mem_rsp_rdata;
    else if (loc_zero)       rsp_rdata = '0;
    else                     rsp_rdata = store_rdata;
  end

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  // R8
  no_fwd_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> !mem_req_valid);
  // R7
  fwd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata)));
  // R6
  fwd_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req_valid) && $past(intercept_on)) |-> ((mem_req_addr >> WIN_BITS) != '0));
endmodule

// File: tb/tb_probe_alias_mem.sv
module tb_probe_alias_mem;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [4:0]  cfg_row = 5'd12, cfg_bank = 5'd3, cfg_col = 5'd13;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1, sel = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;

  logic        rdy_a, rdy_b, rdy_c, rv_a, rv_b, rv_c;
  logic [31:0] rd_a, rd_b, rd_c;
  logic        mrv_a, mw_a, mrr_a, mrv_b, mw_b, mrr_b, mrv_c, mw_c, mrr_c;
  logic [31:0] ma_a, md_a, ma_b, md_b, ma_c, md_c;
  logic        io_a, io_b, io_c, se_a, se_b, se_c;

  logic        pend = 1'b0;
  logic [31:0] bk_rdata = '0, last_addr = '0, last_wdata = '0;
  logic        last_write = 1'b0;
  logic [31:0] bk_mem [64];
  int          fwd_cnt = 0, bad_fwd = 0;

  probe_alias_mem #(.MEM_SIZE_MB(256)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_row_bits(cfg_row), .cfg_bank_bits(cfg_bank),
    .cfg_col_bits(cfg_col), .req_valid(req_valid && !sel), .req_ready(rdy_a),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rv_a), .rsp_ready(rsp_ready), .rsp_rdata(rd_a),
    .mem_req_valid(mrv_a), .mem_req_ready(1'b1), .mem_req_write(mw_a),
    .mem_req_addr(ma_a), .mem_req_wdata(md_a), .mem_rsp_valid(pend),
    .mem_rsp_ready(mrr_a), .mem_rsp_rdata(bk_rdata), .intercept_on(io_a), .size_err(se_a));

  probe_alias_mem #(.MEM_SIZE_MB(300)) dut_bad (
    .clk(clk), .rst_n(rst_n), .cfg_row_bits(cfg_row), .cfg_bank_bits(cfg_bank),
    .cfg_col_bits(cfg_col), .req_valid(req_valid && sel), .req_ready(rdy_b),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rv_b), .rsp_ready(rsp_ready), .rsp_rdata(rd_b),
    .mem_req_valid(mrv_b), .mem_req_ready(1'b1), .mem_req_write(mw_b),
    .mem_req_addr(ma_b), .mem_req_wdata(md_b), .mem_rsp_valid(1'b0),
    .mem_rsp_ready(mrr_b), .mem_rsp_rdata(32'h0), .intercept_on(io_b), .size_err(se_b));

  probe_alias_mem #(.MEM_SIZE_MB(1024)) dut_1g (
    .clk(clk), .rst_n(rst_n), .cfg_row_bits(cfg_row), .cfg_bank_bits(cfg_bank),
    .cfg_col_bits(cfg_col), .req_valid(1'b0), .req_ready(rdy_c),
    .req_write(1'b0), .req_addr(32'h0), .req_wdata(32'h0),
    .rsp_valid(rv_c), .rsp_ready(1'b1), .rsp_rdata(rd_c),
    .mem_req_valid(mrv_c), .mem_req_ready(1'b1), .mem_req_write(mw_c),
    .mem_req_addr(ma_c), .mem_req_wdata(md_c), .mem_rsp_valid(1'b0),
    .mem_rsp_ready(mrr_c), .mem_rsp_rdata(32'h0), .intercept_on(io_c), .size_err(se_c));

  // Backing memory model: accepts at once, answers one cycle later.
  always @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (mrv_a) begin
      pend       <= 1'b1;
      last_write <= mw_a;
      last_addr  <= ma_a;
      last_wdata <= md_a;
      fwd_cnt    <= fwd_cnt + 1;
      if (mw_a) begin
        bk_mem[ma_a[7:2]] <= md_a;
        bk_rdata          <= 32'h0;
      end else begin
        bk_rdata <= bk_mem[ma_a[7:2]];
      end
    end else if (mrr_a && pend) begin
      pend <= 1'b0;
    end
    if (rst_n && mrv_b) bad_fwd <= bad_fwd + 1;
  end

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  function automatic logic m_ready(); return sel ? rdy_b : rdy_a; endfunction
  function automatic logic m_valid(); return sel ? rv_b : rv_a; endfunction
  function automatic logic [31:0] m_data(); return sel ? rd_b : rd_a; endfunction

  task automatic xact(input logic wr, input logic [31:0] a, input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!m_ready()) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!m_valid()) @(negedge clk);
    q = m_data();
    @(negedge clk);
  endtask

  task automatic set_cfg(input int r, input int b, input int c);
    @(negedge clk);
    cfg_row = 5'(r); cfg_bank = 5'(b); cfg_col = 5'(c);
    @(negedge clk);
  endtask

  task automatic t_reset_geometry();
    logic [31:0] q;
    set_cfg(12, 3, 13);
    chk_eq("R2 match no intercept", {31'b0, io_a}, 32'd0);
    chk_eq("R1 256 size ok", {31'b0, se_a}, 32'd0);
    chk_eq("R1 unsupported size_err", {31'b0, se_b}, 32'd1);
    chk_eq("R1 1024 mismatch on 12 rows", {31'b0, io_c}, 32'd1);
    set_cfg(14, 3, 13);
    chk_eq("R1 1024 match on 14 rows", {31'b0, io_c}, 32'd0);
    chk_eq("R2 row mismatch", {31'b0, io_a}, 32'd1);
    set_cfg(12, 2, 13);
    chk_eq("R2 bank mismatch", {31'b0, io_a}, 32'd1);
    set_cfg(12, 3, 10);
    chk_eq("R2 col mismatch", {31'b0, io_a}, 32'd1);
    set_cfg(14, 3, 13);
    xact(1'b0, 32'h0000_0000, 0, q); chk_eq("R9 cell zero after reset", q, 0);
    xact(1'b0, 32'h0000_2000, 0, q); chk_eq("R9 cell zero after reset", q, 0);
    xact(1'b0, 32'h0800_0000, 0, q); chk_eq("R9 cell zero after reset", q, 0);
  endtask

  task automatic t_alias();
    logic [31:0] q;
    xact(1'b1, 32'h0000_0100, 32'h11, q); chk_eq("R10 write rsp zero", q, 0);
    xact(1'b0, 32'h0000_01F0, 0, q); chk_eq("R5 col alias", q, 32'h11);
    xact(1'b0, 32'h0000_0080, 0, q); chk_eq("R4 other col msb", q, 0);
    xact(1'b1, 32'h0000_4000, 32'h22, q);
    xact(1'b0, 32'h0000_6000, 0, q); chk_eq("R5 bank alias", q, 32'h22);
    xact(1'b1, 32'h0800_0000, 32'h33, q);
    xact(1'b1, 32'h2000_0000, 32'h44, q);
    xact(1'b0, 32'h0000_0000, 0, q); chk_eq("R4 row bit beyond width ignored", q, 32'h44);
    xact(1'b0, 32'h1000_0000, 0, q); chk_eq("R4 row bit 12 ignored", q, 32'h44);
    xact(1'b0, 32'h2800_0000, 0, q); chk_eq("R4 row msb 11 counted", q, 32'h33);
  endtask

  task automatic t_split();
    logic [31:0] q;
    set_cfg(14, 2, 10);
    xact(1'b0, 32'h0000_0800, 0, q); chk_eq("R3 bank field at bit 10", q, 32'h22);
    xact(1'b0, 32'h0000_0100, 0, q); chk_eq("R3 col field", q, 32'h11);
    xact(1'b0, 32'h0080_0000, 0, q); chk_eq("R3 row field at bit 12", q, 32'h33);
    xact(1'b0, 32'h0000_1000, 0, q); chk_eq("R3 row bit0 maps to cell 0", q, 32'h44);
    set_cfg(14, 3, 13);
  endtask

  task automatic t_window_pass();
    logic [31:0] q;
    int c0;
    c0 = fwd_cnt;
    xact(1'b1, 32'h4000_0000, 32'h55, q);
    chk_eq("R6 above window forwarded", fwd_cnt - c0, 1);
    chk_eq("R6 forwarded addr", last_addr, 32'h4000_0000);
    xact(1'b0, 32'h4000_0000, 0, q); chk_eq("R6 backing read", q, 32'h55);
    xact(1'b0, 32'h0000_0000, 0, q); chk_eq("R6 window still intercepted", q, 32'h44);
    set_cfg(12, 3, 13);
    xact(1'b1, 32'h0000_0104, 32'h66, q);
    chk_eq("R7 forwarded addr", last_addr, 32'h0000_0104);
    chk_eq("R7 forwarded data", last_wdata, 32'h66);
    chk_eq("R7 forwarded write", {31'b0, last_write}, 32'd1);
    xact(1'b0, 32'h0000_0104, 0, q); chk_eq("R7 backing data returned", q, 32'h66);
    chk_eq("R7 read forwarded as read", {31'b0, last_write}, 32'd0);
    set_cfg(14, 3, 13);
    xact(1'b0, 32'h0000_0100, 0, q); chk_eq("R7 cells untouched by pass-through", q, 32'h11);
  endtask

  task automatic t_bad_size();
    logic [31:0] q;
    sel = 1'b1;
    xact(1'b1, 32'h0000_0100, 32'h77, q);
    xact(1'b0, 32'h0000_0100, 0, q); chk_eq("R8 read zero, write dropped", q, 0);
    xact(1'b0, 32'h4000_0000, 0, q); chk_eq("R8 high read zero", q, 0);
    chk_eq("R8 nothing forwarded", bad_fwd, 0);
    sel = 1'b0;
  endtask

  task automatic t_backpressure();
    logic [31:0] q0;
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0000_0100;
    @(negedge clk);
    req_valid = 1'b0;
    q0 = rd_a;
    chk_eq("R10 rsp valid", {31'b0, rv_a}, 32'd1);
    repeat (3) @(negedge clk);
    chk_eq("R10 rsp held", {31'b0, rv_a}, 32'd1);
    chk_eq("R10 busy not ready", {31'b0, rdy_a}, 32'd0);
    chk_eq("R10 data stable", rd_a, q0);
    chk_eq("R10 data value", rd_a, 32'h11);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk_eq("R10 released", {31'b0, rv_a}, 32'd0);
    chk_eq("R10 ready again", {31'b0, rdy_a}, 32'd1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R10 idle ready after reset", {31'b0, rdy_a}, 32'd1);
    chk_eq("R10 no rsp after reset", {31'b0, rv_a}, 32'd0);
    t_reset_geometry();
    t_alias();
    t_split();
    t_window_pass();
    t_bad_size();
    t_backpressure();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected 0", 1);
    finish_run();
  end
endmodule